// File: doc/BRIEF.md
# Serial Register Access Port

This block is the serial front end of a peripheral that exposes an 8-bit register file of 32 entries to an external host. The host runs SPI mode 0 (clock idles low, data sampled on the rising clock edge, changed on the falling edge) and frames every access with an active-low chip select. Each access is exactly one 16-bit word, sent most significant bit first. The upper byte holds a direction flag in its top bit (1 = write, 0 = read) and a 7-bit address field, of which the lower five bits select the register. The lower byte carries write data from the host or, in a read, the register contents returned on MISO.

The serial clock, chip select and MOSI are brought into the system clock domain through a synchronizer and then decoded. After the eighth bit of a read word the block issues a one-cycle read strobe, so the returned byte is loaded before the ninth bit is shifted. After the sixteenth bit of a write word it issues a one-cycle write strobe with the captured address and data. Address zero is not a register: a read of it pops the receive queue and a write pushes the transmit queue. The top address returns a fixed revision code.

Top module: `spi_regbus_slave`

## Requirements
- R1: A 16-bit word with bit 15 = 1 and address field bits 14..8 in the range 0x01..0x1E produces exactly one `reg_wr_o` pulse, with `reg_addr_o` equal to bits 12..8 and `reg_wdata_o` equal to bits 7..0.
- R2: A 16-bit word with bit 15 = 0 and address 0x01..0x1E produces exactly one `reg_rd_o` pulse with that address. In bits 7..0 of the same word, MISO returns the `reg_rdata_i` value sampled during that pulse, MSB first.
- R3: MISO is 0 throughout the upper byte of every word and while chip select is high. It is also 0 out of reset.
- R4: A read of address 0x00 produces one `rxq_pop_o` pulse and no `reg_rd_o`. It returns the `rxq_data_i` value present during the pop.
- R5: A write of address 0x00 produces one `txq_push_o` pulse with the data on `reg_wdata_o`, and no `reg_wr_o`.
- R6: A read of address 0x1F returns the parameter `REV_CODE` (default 0xA0) and produces no strobe. A write of address 0x1F produces no strobe.
- R7: A word whose address field has bit 13 or bit 14 set produces no strobe of any kind. A read of such an address returns 0x00.
- R8: When chip select rises before the 16th bit, no write or push strobe is produced. When it rises before the 8th bit, no read or pop strobe is produced. The next word is decoded from its own first bit.
- R9: Serial clocks beyond the 16th in one chip-select window change nothing: no further strobe is produced.
- R10: At most one of `reg_wr_o`, `reg_rd_o`, `rxq_pop_o` and `txq_push_o` is high in any cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Active-low chip select framing one word |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr_o | output | 5 | Register address, valid with any strobe |
| reg_wdata_o | output | 8 | Write data for register or transmit queue |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, sampled during `reg_rd_o` |
| rxq_pop_o | output | 1 | One-cycle receive queue pop strobe |
| rxq_data_i | input | 8 | Receive queue head, sampled during `rxq_pop_o` |
| txq_push_o | output | 1 | One-cycle transmit queue push strobe |

## Verification
The bench aims at the address decode edges: address zero in each direction, the revision address and addresses with high field bits set. If the decode were wrong, a register strobe would appear where a queue strobe belongs, or the revision code would be replaced by register data. It cuts words short at the boundaries that matter (before and after the eighth bit, just before the sixteenth). A counter that failed to clear on chip select would leak a strobe or corrupt the next word. Over-long words check that the counter saturates instead of firing a second write. MISO is sampled bit by bit at each rising serial clock, so a shifter that moved one edge early or late shows up as a shifted byte.

// File: rtl/spi_regbus_pkg.sv
package spi_regbus_pkg;
    localparam int FRAME_W    = 16;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int CNT_W      = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_REG  = 2'd1,
        SRC_FIFO = 2'd2,
        SRC_REV  = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic                sclk_prev;
        logic [CNT_W-1:0]    bit_cnt;
        logic [FRAME_W-2:0]  shreg;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic                rd;
        logic                wr;
        logic                pop;
        logic                push;
        logic                load;
        logic                shift;
        rd_src_e             src;
    } frame_state_t;

    // Classify one header byte into the target it selects.
    function automatic rd_src_e classify(input logic [DATA_W-1:0] hdr);
        logic [ADDR_W-1:0] a;
        a = hdr[ADDR_W-1:0];
        if (hdr[DATA_W-2:ADDR_W] != '0) return SRC_NONE;
        if (a == '0)                    return SRC_FIFO;
        if (a == {ADDR_W{1'b1}})        return SRC_REV;
        return SRC_REG;
    endfunction
endpackage

// File: rtl/spi_regbus_sync.sv
module spi_regbus_sync #(
    parameter int            WIDTH   = 3,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [WIDTH-1:0] stage_d;
        if (s == 0) begin : g_first
            assign stage_d = async_i;
        end else begin : g_next
            assign stage_d = stage_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else        stage_q[s] <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regbus_frame.sv
module spi_regbus_frame
    import spi_regbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              pop_o,
    output logic              push_o,
    output logic              load_o,
    output logic              shift_o,
    output rd_src_e           src_o
);
    frame_state_t q, d;

    logic               rise, fall;
    logic [FRAME_W-1:0] nxt;
    logic [DATA_W-1:0]  hdr_first, hdr_full;
    rd_src_e            cls_first, cls_full;

    always_comb begin
        d         = q;
        d.rd      = 1'b0;
        d.wr      = 1'b0;
        d.pop     = 1'b0;
        d.push    = 1'b0;
        d.load    = 1'b0;
        d.shift   = 1'b0;
        d.sclk_prev = sclk_i;

        rise      = sclk_i & ~q.sclk_prev;
        fall      = ~sclk_i & q.sclk_prev;
        nxt       = {q.shreg, mosi_i};
        hdr_first = nxt[DATA_W-1:0];
        hdr_full  = nxt[FRAME_W-1:DATA_W];
        cls_first = classify(hdr_first);
        cls_full  = classify(hdr_full);

        if (cs_n_i) begin
            d.bit_cnt = '0;
        end else begin
            // Falls after bits 9..15 advance the returned byte.
            if (fall && q.bit_cnt > CNT_W'(DATA_W) && q.bit_cnt < CNT_W'(FRAME_W))
                d.shift = 1'b1;
            if (rise && q.bit_cnt < CNT_W'(FRAME_W)) begin
                d.shreg   = nxt[FRAME_W-2:0];
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == CNT_W'(DATA_W - 1)) begin
                    d.addr = hdr_first[ADDR_W-1:0];
                    if (!hdr_first[DATA_W-1]) begin
                        d.load = 1'b1;
                        d.src  = cls_first;
                        case (cls_first)
                            SRC_REG:  d.rd  = 1'b1;
                            SRC_FIFO: d.pop = 1'b1;
                            default:  ;
                        endcase
                    end
                end
                if (q.bit_cnt == CNT_W'(FRAME_W - 1)) begin
                    d.addr  = hdr_full[ADDR_W-1:0];
                    d.wdata = nxt[DATA_W-1:0];
                    if (hdr_full[DATA_W-1]) begin
                        case (cls_full)
                            SRC_REG:  d.wr   = 1'b1;
                            SRC_FIFO: d.push = 1'b1;
                            default:  ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{default: '0, src: SRC_NONE};
        else        q <= d;
    end

    assign addr_o  = q.addr;
    assign wdata_o = q.wdata;
    assign rd_o    = q.rd;
    assign wr_o    = q.wr;
    assign pop_o   = q.pop;
    assign push_o  = q.push;
    assign load_o  = q.load;
    assign shift_o = q.shift;
    assign src_o   = q.src;
endmodule

// File: rtl/spi_regbus_txsh.sv
module spi_regbus_txsh #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    output logic              miso_o
);
    logic [DATA_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i)      sh_d = '0;
        else if (load_i)  sh_d = load_data_i;
        else if (shift_i) sh_d = {sh_q[DATA_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso_o = sh_q[DATA_W-1];
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
    import spi_regbus_pkg::*;
#(
    parameter logic [7:0] REV_CODE    = 8'hA0,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic [4:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_wr_o,
    output logic       reg_rd_o,
    input  logic [7:0] reg_rdata_i,
    output logic       rxq_pop_o,
    input  logic [7:0] rxq_data_i,
    output logic       txq_push_o
);
    logic [2:0]        pins_s;
    logic              sclk_s, cs_n_s, mosi_s;
    logic              load, shift;
    rd_src_e           src;
    logic [DATA_W-1:0] load_data;

    spi_regbus_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_sclk, spi_cs_n, spi_mosi}),
        .sync_o  (pins_s)
    );
    assign {sclk_s, cs_n_s, mosi_s} = pins_s;

    spi_regbus_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_s),
        .cs_n_i  (cs_n_s),
        .mosi_i  (mosi_s),
        .addr_o  (reg_addr_o),
        .wdata_o (reg_wdata_o),
        .rd_o    (reg_rd_o),
        .wr_o    (reg_wr_o),
        .pop_o   (rxq_pop_o),
        .push_o  (txq_push_o),
        .load_o  (load),
        .shift_o (shift),
        .src_o   (src)
    );

    always_comb begin
        case (src)
            SRC_REG:  load_data = reg_rdata_i;
            SRC_FIFO: load_data = rxq_data_i;
            SRC_REV:  load_data = REV_CODE;
            default:  load_data = '0;
        endcase
    end

    spi_regbus_txsh #(.DATA_W(DATA_W)) u_txsh (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cs_n_s),
        .load_i      (load),
        .load_data_i (load_data),
        .shift_i     (shift),
        .miso_o      (spi_miso)
    );
endmodule

// File: rtl/spi_regbus_slave_chk.sv
module spi_regbus_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso,
    input logic [4:0] reg_addr_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o,
    input logic       rxq_pop_o,
    input logic       txq_push_o
);
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_o, reg_rd_o, rxq_pop_o, txq_push_o}));

    p_wr_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    p_rd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

    p_idle_miso_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_miso);

    p_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_pop_o |-> (reg_addr_o == 5'd0));

    p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        txq_push_o |-> (reg_addr_o == 5'd0));

    p_reg_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_o || reg_wr_o) |-> (reg_addr_o != 5'd0 && reg_addr_o != 5'h1F));
endmodule

bind spi_regbus_slave spi_regbus_slave_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .reg_addr_o (reg_addr_o),
    .reg_wr_o   (reg_wr_o),
    .reg_rd_o   (reg_rd_o),
    .rxq_pop_o  (rxq_pop_o),
    .txq_push_o (txq_push_o)
);

// File: tb/spi_regbus_slave_tb.sv
`timescale 1ns/1ps
module spi_regbus_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [4:0] reg_addr_o;
    logic [7:0] reg_wdata_o;
    logic       reg_wr_o, reg_rd_o, rxq_pop_o, txq_push_o;
    logic [7:0] reg_rdata_i, rxq_data_i;

    logic [7:0] regs [32];
    logic [7:0] rx_head = 8'h5A;

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_rd = 0, n_pop = 0, n_push = 0;
    logic [4:0] wr_a;
    logic [7:0] wr_d, push_d;
    bit done = 0;

    always #4 clk = ~clk;

    spi_regbus_slave dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr_o(reg_addr_o),
        .reg_wdata_o(reg_wdata_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
        .reg_rdata_i(reg_rdata_i), .rxq_pop_o(rxq_pop_o), .rxq_data_i(rxq_data_i),
        .txq_push_o(txq_push_o)
    );

    // Register file and receive queue models
    assign reg_rdata_i = regs[reg_addr_o];
    assign rxq_data_i  = rx_head;

    initial for (int i = 0; i < 32; i++) regs[i] = 8'(i * 7 + 3);

    always @(posedge clk) begin
        if (reg_wr_o)  regs[reg_addr_o] <= reg_wdata_o;
        if (rxq_pop_o) rx_head <= rx_head + 8'd1;
    end

    always @(negedge clk) if (rst_n) begin
        if (reg_wr_o)   begin n_wr++;   wr_a = reg_addr_o; wr_d = reg_wdata_o; end
        if (reg_rd_o)   n_rd++;
        if (rxq_pop_o)  n_pop++;
        if (txq_push_o) begin n_push++; push_d = reg_wdata_o; end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [15:0] w, input int nbits, output logic [15:0] got);
        got = '0;
        spi_cs_n = 1'b0;
        #64;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? w[15-i] : 1'b1;
            #64;
            spi_sclk = 1'b1;
            if (i < 16) got[15-i] = spi_miso;
            #64;
            spi_sclk = 1'b0;
        end
        #64;
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        #128;
    endtask

    task automatic t_reset();
        chk(spi_miso == 1'b0, "R3 reset miso", spi_miso, 0);
        chk({reg_wr_o, reg_rd_o, rxq_pop_o, txq_push_o} == 4'b0, "R10 reset strobes",
            {reg_wr_o, reg_rd_o, rxq_pop_o, txq_push_o}, 0);
    endtask

    task automatic t_write();
        logic [15:0] g;
        int w0 = n_wr;
        spi_xfer({1'b1, 7'h05, 8'h3C}, 16, g);
        chk(n_wr == w0 + 1, "R1 write count", n_wr - w0, 1);
        chk(wr_a == 5'h05 && wr_d == 8'h3C, "R1 write addr/data", {wr_a, wr_d}, {5'h05, 8'h3C});
        spi_xfer({1'b1, 7'h1E, 8'hC3}, 16, g);
        chk(n_wr == w0 + 2 && wr_a == 5'h1E && wr_d == 8'hC3, "R1 write top reg",
            {wr_a, wr_d}, {5'h1E, 8'hC3});
    endtask

    task automatic t_read();
        logic [15:0] g;
        int r0 = n_rd;
        spi_xfer({1'b0, 7'h05, 8'h00}, 16, g);
        chk(g[7:0] == 8'h3C, "R2 read back written", g[7:0], 8'h3C);
        chk(g[15:8] == 8'h00, "R3 first byte zero", g[15:8], 0);
        chk(n_rd == r0 + 1, "R2 read count", n_rd - r0, 1);
        spi_xfer({1'b0, 7'h11, 8'h00}, 16, g);
        chk(g[7:0] == 8'h7A, "R2 read preset", g[7:0], 8'h7A);
        spi_xfer({1'b0, 7'h01, 8'h00}, 16, g);
        chk(g[7:0] == 8'h0A, "R2 read addr1", g[7:0], 8'h0A);
    endtask

    task automatic t_fifo();
        logic [15:0] g;
        int r0 = n_rd, w0 = n_wr, p0 = n_pop, q0 = n_push;
        spi_xfer({1'b0, 7'h00, 8'h00}, 16, g);
        chk(g[7:0] == 8'h5A, "R4 pop first", g[7:0], 8'h5A);
        spi_xfer({1'b0, 7'h00, 8'h00}, 16, g);
        chk(g[7:0] == 8'h5B, "R4 pop second", g[7:0], 8'h5B);
        chk(n_pop == p0 + 2 && n_rd == r0, "R4 pop strobes", n_pop - p0, 2);
        spi_xfer({1'b1, 7'h00, 8'h77}, 16, g);
        chk(n_push == q0 + 1 && push_d == 8'h77, "R5 push", push_d, 8'h77);
        chk(n_wr == w0, "R5 no reg write", n_wr - w0, 0);
    endtask

    task automatic t_rev();
        logic [15:0] g;
        int r0 = n_rd, w0 = n_wr;
        spi_xfer({1'b0, 7'h1F, 8'h00}, 16, g);
        chk(g[7:0] == 8'hA0, "R6 revision code", g[7:0], 8'hA0);
        spi_xfer({1'b1, 7'h1F, 8'h55}, 16, g);
        chk(n_rd == r0 && n_wr == w0, "R6 no strobe", (n_rd - r0) + (n_wr - w0), 0);
    endtask

    task automatic t_hi_addr();
        logic [15:0] g;
        int s0 = n_rd + n_wr + n_pop + n_push;
        spi_xfer({1'b0, 7'h25, 8'h00}, 16, g);
        chk(g == 16'h0000, "R7 high addr read", g, 0);
        spi_xfer({1'b1, 7'h45, 8'h99}, 16, g);
        spi_xfer({1'b1, 7'h20, 8'h11}, 16, g);
        chk(n_rd + n_wr + n_pop + n_push == s0, "R7 no strobe",
            n_rd + n_wr + n_pop + n_push - s0, 0);
        spi_xfer({1'b0, 7'h05, 8'h00}, 16, g);
        chk(g[7:0] == 8'h3C, "R7 reg 5 untouched", g[7:0], 8'h3C);
    endtask

    task automatic t_abort();
        logic [15:0] g;
        int w0 = n_wr, r0 = n_rd, q0 = n_push;
        spi_xfer({1'b1, 7'h07, 8'hEE}, 15, g);
        chk(n_wr == w0, "R8 short write dropped", n_wr - w0, 0);
        spi_xfer({1'b1, 7'h00, 8'hEE}, 9, g);
        chk(n_push == q0, "R8 short push dropped", n_push - q0, 0);
        spi_xfer({1'b0, 7'h07, 8'h00}, 5, g);
        chk(n_rd == r0, "R8 short read dropped", n_rd - r0, 0);
        spi_xfer({1'b1, 7'h09, 8'h42}, 16, g);
        chk(n_wr == w0 + 1 && wr_a == 5'h09 && wr_d == 8'h42, "R8 next frame clean",
            {wr_a, wr_d}, {5'h09, 8'h42});
    endtask

    task automatic t_long();
        logic [15:0] g;
        int w0 = n_wr;
        spi_xfer({1'b1, 7'h0C, 8'hA5}, 22, g);
        chk(n_wr == w0 + 1, "R9 single write on long frame", n_wr - w0, 1);
        chk(wr_a == 5'h0C && wr_d == 8'hA5, "R9 long frame data", {wr_a, wr_d}, {5'h0C, 8'hA5});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_write();
        t_read();
        t_fifo();
        t_rev();
        t_hi_addr();
        t_abort();
        t_long();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule